// File: doc/BRIEF.md
# Filtered Overcurrent Shutdown Latch

This block is the digital fault logic of one channel of a bus signal driver. Two analog comparators report that the driver is sourcing or sinking too much current. Either report is enough to count as an overcurrent. A deglitch counter runs while the overcurrent condition is present. It lets the short current peaks of normal capacitive slewing pass, and it trips only when the condition lasts long enough. A trip sets a shutdown latch, which puts the driver in high impedance for the rest of the frame.

The frame engine sends an end-of-frame strobe. This strobe releases the latch and restarts the deglitch count, so the driver tries again in the next frame. A sticky error bit sits in the channel status register. It records both raw overcurrent and CRC errors, and a status read clears it.

Top module: `ocs_shutdown`

## Requirements
- R1: The sourcing and sinking flags are combined by OR before filtering, so either flag, or the two taking turns cycle by cycle, counts as one continuous overcurrent.
- R2: When the combined flag is high on FILTER_CYCLES consecutive rising clock edges, `drv_hiz_o` goes to 1 after the last of those edges.
- R3: A combined overcurrent that lasts FILTER_CYCLES-1 edges or fewer leaves `drv_hiz_o` at 0. A single low cycle restarts the count from zero.
- R4: Once `drv_hiz_o` is 1, it stays 1 until an end-of-frame strobe, whatever the flags do.
- R5: An end-of-frame strobe (`frame_end_i` high at an edge) clears `drv_hiz_o` after that edge and resets the deglitch count. A persistent overcurrent therefore needs another full FILTER_CYCLES edges to shut the driver down again.
- R6: `err_flag_o` goes to 1 after any edge at which the raw combined flag or `crc_err_i` is high. This holds even for a single cycle, and even when the flag is too short to trip the shutdown.
- R7: `err_flag_o` is sticky. It goes back to 0 only after an edge at which `stat_rd_i` is high while no new error is present.
- R8: When an error and a status read occur at the same edge, `err_flag_o` remains 1.
- R9: A low `rst_n` at an edge clears `drv_hiz_o`, `err_flag_o` and the deglitch count.
- R10: When end-of-frame and the final filter edge fall on the same edge, end-of-frame wins and `drv_hiz_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oc_src_i | input | 1 | Sourcing overcurrent flag from comparator |
| oc_snk_i | input | 1 | Sinking overcurrent flag from comparator |
| frame_end_i | input | 1 | End-of-frame strobe, one cycle |
| crc_err_i | input | 1 | CRC error strobe |
| stat_rd_i | input | 1 | Status register read strobe |
| drv_hiz_o | output | 1 | 1 = driver shut down, bus high impedance |
| err_flag_o | output | 1 | Sticky channel error bit |

## Verification
The bound checker watches several properties on every cycle:
- No shutdown appears without a run of FILTER_CYCLES combined-flag edges since the last frame end or low cycle. A checker-side counter supplies this run length.
- The latch holds until frame end, and frame end releases it.
- Any error sets the status bit, the bit stays set until a read, and reset clears everything.

Only the bench's directed scenarios show the rest:
- The exact trip cycle.
- That runs one edge short do not trip.
- That sourcing and sinking flags taking turns still trip.
- The retry timing after frame end under a persistent fault.
- The tie between a read and a new error.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

    typedef struct packed {
        logic off;
    } latch_state_t;

    typedef struct packed {
        logic err;
    } stat_state_t;

endpackage

// File: rtl/ocs_filter.sv
module ocs_filter #(
    parameter int FILTER_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic snk_i,
    input  logic clr_i,
    output logic raw_o,
    output logic trip_o
);
    localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FILTER_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILTER_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic        comb_oc;

    always_comb begin
        comb_oc = src_i | snk_i;
        st_d    = st_q;
        if (clr_i || !comb_oc) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        raw_o  = comb_oc;
        trip_o = comb_oc && !clr_i && (st_q.cnt >= CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocs_latch.sv
module ocs_latch
    import ocs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic eof_i,
    output logic off_o
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eof_i) begin
            st_d.off = 1'b0;
        end else if (trip_i) begin
            st_d.off = 1'b1;
        end
        off_o = st_q.off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocs_status.sv
module ocs_status
    import ocs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic crc_i,
    input  logic rd_i,
    output logic err_o
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = (st_q.err && !rd_i) || raw_i || crc_i;
        err_o    = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocs_shutdown.sv
module ocs_shutdown #(
    parameter int FILTER_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_src_i,
    input  logic oc_snk_i,
    input  logic frame_end_i,
    input  logic crc_err_i,
    input  logic stat_rd_i,
    output logic drv_hiz_o,
    output logic err_flag_o
);
    logic raw_oc;
    logic trip;

    ocs_filter #(
        .FILTER_CYCLES(FILTER_CYCLES)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (oc_src_i),
        .snk_i (oc_snk_i),
        .clr_i (frame_end_i),
        .raw_o (raw_oc),
        .trip_o(trip)
    );

    ocs_latch latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trip_i(trip),
        .eof_i (frame_end_i),
        .off_o (drv_hiz_o)
    );

    ocs_status stat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_oc),
        .crc_i (crc_err_i),
        .rd_i  (stat_rd_i),
        .err_o (err_flag_o)
    );

endmodule

// File: rtl/ocs_shutdown_chk.sv
module ocs_shutdown_chk #(
    parameter int FILTER_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic oc_src_i,
    input logic oc_snk_i,
    input logic frame_end_i,
    input logic crc_err_i,
    input logic stat_rd_i,
    input logic drv_hiz_o,
    input logic err_flag_o
);
    localparam int RUN_W = $clog2(FILTER_CYCLES + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILTER_CYCLES);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_end_i || !(oc_src_i || oc_snk_i)) begin
            run_q <= '0;
        end else if (run_q < RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R2 / R3: shutdown only after a full filter run
    a_r3_filtered_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_hiz_o) |-> (run_q >= RUN_MAX));

    // R4: latch holds until end of frame
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hiz_o && !frame_end_i) |=> drv_hiz_o);

    // R5 / R10: end of frame releases the driver
    a_r5_eof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> !drv_hiz_o);

    // R6: any error sets the status bit
    a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_i || oc_src_i || oc_snk_i) |=> err_flag_o);

    // R7: sticky without a read
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag_o && !stat_rd_i) |=> err_flag_o);

    // R7: a read with no new error clears
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !crc_err_i && !oc_src_i && !oc_snk_i) |=> !err_flag_o);

    // R9: reset clears outputs
    a_r9_reset: assert property (@(posedge clk)
        !rst_n |=> (!drv_hiz_o && !err_flag_o));

endmodule

bind ocs_shutdown ocs_shutdown_chk #(
    .FILTER_CYCLES(FILTER_CYCLES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_src_i   (oc_src_i),
    .oc_snk_i   (oc_snk_i),
    .frame_end_i(frame_end_i),
    .crc_err_i  (crc_err_i),
    .stat_rd_i  (stat_rd_i),
    .drv_hiz_o  (drv_hiz_o),
    .err_flag_o (err_flag_o)
);

// File: tb/ocs_shutdown_tb_top.sv
`timescale 1ns/1ps
module ocs_shutdown_tb_top;
    localparam int F = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src = 1'b0, snk = 1'b0, eof = 1'b0, crc = 1'b0, rd = 1'b0;
    logic hiz, err;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ocs_shutdown #(.FILTER_CYCLES(F)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_src_i   (src),
        .oc_snk_i   (snk),
        .frame_end_i(eof),
        .crc_err_i  (crc),
        .stat_rd_i  (rd),
        .drv_hiz_o  (hiz),
        .err_flag_o (err)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_all();
        @(negedge clk);
        src = 0; snk = 0; eof = 0; crc = 0; rd = 0;
    endtask

    task automatic frame_end();
        @(negedge clk); src = 0; snk = 0; eof = 1;
        @(negedge clk); eof = 0;
    endtask

    task automatic read_clear();
        @(negedge clk); rd = 1;
        @(negedge clk); rd = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(hiz, 1'b0, "R9 hiz after reset");
        check(err, 1'b0, "R9 err after reset");
        rst_n = 1;
    endtask

    task automatic t_src_alone();
        for (int i = 0; i < F; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); src = 0;
        check(hiz, 1'b1, "R2 src alone trips after F edges");
        frame_end();
        check(hiz, 1'b0, "R5 eof clears");
    endtask

    task automatic t_snk_and_alt();
        for (int i = 0; i < F; i++) begin @(negedge clk); snk = 1; end
        @(negedge clk); snk = 0;
        check(hiz, 1'b1, "R1 snk alone trips");
        frame_end();
        for (int i = 0; i < F; i++) begin
            @(negedge clk); src = (i % 2 == 0); snk = (i % 2 == 1);
        end
        @(negedge clk); src = 0; snk = 0;
        check(hiz, 1'b1, "R1 alternating src/snk trips");
        frame_end();
    endtask

    task automatic t_short();
        for (int i = 0; i < F - 1; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); src = 0;
        @(negedge clk);
        check(hiz, 1'b0, "R3 F-1 edges no trip");
        for (int i = 0; i < F - 1; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); src = 0;
        for (int i = 0; i < F - 1; i++) begin @(negedge clk); snk = 1; end
        @(negedge clk); snk = 0;
        @(negedge clk);
        check(hiz, 1'b0, "R3 gap restarts count");
    endtask

    task automatic t_hold();
        for (int i = 0; i < F; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); src = 0;
        repeat (10) @(negedge clk);
        check(hiz, 1'b1, "R4 holds with flags low");
        crc = 1; @(negedge clk); crc = 0; rd = 1; @(negedge clk); rd = 0;
        check(hiz, 1'b1, "R4 holds across crc and read");
        frame_end();
        check(hiz, 1'b0, "R4 released by eof");
    endtask

    task automatic t_retry();
        for (int i = 0; i < F; i++) begin @(negedge clk); src = 1; end
        @(negedge clk);
        check(hiz, 1'b1, "R5 tripped before retry");
        eof = 1;
        @(negedge clk); eof = 0;
        check(hiz, 1'b0, "R5 cleared at eof with fault present");
        for (int i = 0; i < F - 1; i++) @(negedge clk);
        check(hiz, 1'b0, "R5 not set after F-1 retry edges");
        @(negedge clk);
        check(hiz, 1'b1, "R5 set after full retry window");
        frame_end();
    endtask

    task automatic t_tie_eof();
        for (int i = 0; i < F - 1; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); eof = 1;
        @(negedge clk); eof = 0; src = 0;
        check(hiz, 1'b0, "R10 eof beats final filter edge");
        @(negedge clk);
        check(hiz, 1'b0, "R10 still clear");
    endtask

    task automatic t_err();
        read_clear();
        check(err, 1'b0, "R7 read clears");
        @(negedge clk); src = 1;
        @(negedge clk); src = 0;
        check(err, 1'b1, "R6 one-cycle oc sets err");
        check(hiz, 1'b0, "R6 one-cycle oc no trip");
        repeat (4) @(negedge clk);
        check(err, 1'b1, "R7 sticky");
        read_clear();
        check(err, 1'b0, "R7 cleared by read");
        @(negedge clk); crc = 1;
        @(negedge clk); crc = 0;
        check(err, 1'b1, "R6 crc sets err");
        @(negedge clk); rd = 1; crc = 1;
        @(negedge clk); rd = 0; crc = 0;
        check(err, 1'b1, "R8 new error beats read");
        @(negedge clk); rd = 1; snk = 1;
        @(negedge clk); rd = 0; snk = 0;
        check(err, 1'b1, "R8 oc beats read");
        read_clear();
        check(err, 1'b0, "R7 final clear");
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < F; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); src = 0;
        check(hiz, 1'b1, "R2 tripped before reset");
        rst_n = 0;
        @(negedge clk); rst_n = 1;
        check(hiz, 1'b0, "R9 reset clears latch");
        check(err, 1'b0, "R9 reset clears err");
        for (int i = 0; i < F - 1; i++) begin @(negedge clk); src = 1; end
        @(negedge clk); src = 0;
        check(hiz, 1'b0, "R9 reset cleared counter");
    endtask

    initial begin
        t_reset();
        idle_all();
        t_src_alone();
        t_snk_and_alt();
        t_short();
        t_hold();
        t_retry();
        t_tie_eof();
        t_err();
        t_reset_mid();
        idle_all();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule